// File: doc/BRIEF.md
# Ping-Pong Capture Averaging Sequencer

This block sequences one measurement point of a coherent receiver. A stereo sample stream lands in a two-half ping-pong buffer. Each half holds 48 stereo sample pairs taken at 192 kHz, so one buffer spans 250 us. Two completion events, one per half, tell the sequencer that a buffer is ready. For every ready buffer the sequencer decides between two actions. It can throw the buffer away and clear the downstream correlator accumulators, because the signal has not settled yet. Or it can let the correlator add the buffer into its running sums. The sample memory and the arithmetic sit outside the block.

A measurement starts with a one-cycle start pulse that carries a settling delay, counted in buffers, and a compact bandwidth code. The code is the number of buffers to average minus one, so code 0 averages 1 buffer, 3 averages 4, 39 averages 40 and 131 averages 132. The first buffers, as many as the delay asks for, are discarded. The next code+1 buffers are forwarded. A one-cycle done pulse marks the last forwarded buffer. After that the block stays idle until the next start.

Top module: `capture_avg_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, half_sel, acc_clr, proc_en and meas_done are all 0.
- R2: After a start with settling delay D, exactly D buffer events each give an acc_clr pulse with no proc_en pulse. A buffer is discarded while the internal count, loaded with D + code + 1 and decremented per event, is at least code + 2.
- R3: After the discards, exactly code+1 buffer events each give a proc_en pulse. This holds for codes 0, 3, 39 and 131, which stand for 1, 4, 40 and 132 buffers.
- R4: half_sel tells which half each action refers to. A first-half event (evt_lo) sets it to 0 and a second-half event (evt_hi) sets it to 1. It holds its value between events.
- R5: meas_done is a single-cycle pulse. It coincides with the proc_en pulse of the last forwarded buffer and occurs once per measurement.
- R6: Buffer events while no measurement is active cause no acc_clr, proc_en or meas_done pulse and leave half_sel unchanged. This includes events after done.
- R7: A start while a measurement is active gives one acc_clr pulse in the cycle after the start. It then reloads the sequence from the new delay and code.
- R8: A buffer event in the same cycle as a start is ignored.
- R9: acc_clr, proc_en and meas_done appear in the clock cycle after the buffer event that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle start of a measurement point |
| settle_dly | input | 8 | Settling delay in buffers, sampled at start |
| bw_code | input | 8 | Buffers to average minus one, sampled at start |
| evt_lo | input | 1 | First buffer half complete (one-cycle pulse) |
| evt_hi | input | 1 | Second buffer half complete (one-cycle pulse) |
| half_sel | output | 1 | Half the current action refers to: 0 first, 1 second |
| acc_clr | output | 1 | Clear the accumulators (buffer discarded or restart) |
| proc_en | output | 1 | Accumulate the selected half |
| meas_done | output | 1 | Last buffer of the point forwarded |

## Verification
The main function is run once for each of the four bandwidth codes, each paired with a different settling delay, including zero. Counting the clear and process pulses separately shows whether the discard/forward boundary sits at code+2. Events alternate between halves, so a stuck or inverted half select shows up on every forwarded buffer. Extra events after done, events while idle, a start that coincides with an event, and a restart in the middle of the discard phase each separate one kind of wrong count or wrong ordering. A single-event point checks the one-cycle output latency.

// File: rtl/cap_seq_pkg.sv
// Package: shared types for the capture averaging sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package cap_seq_pkg;

    // Which ping-pong half a buffer event refers to
    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } half_e;

    // Action chosen for one buffer event
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_DISCARD = 2'd1,
        ACT_KEEP    = 2'd2
    } buf_act_e;

endpackage

// File: rtl/cap_evt_decode.sv
// Module: cap_evt_decode
// Merges the two half-complete events into one event strobe and a half tag.
// Assumes the two events are single-cycle pulses; if both arrive together
// the second half is reported.
module cap_evt_decode
    import cap_seq_pkg::*;
(
    input  logic  evt_lo,
    input  logic  evt_hi,
    output logic  evt_any,
    output half_e evt_half
);

    // Purpose: combine the strobes and tag the half
    always_comb begin
        evt_any  = evt_lo | evt_hi;
        evt_half = evt_hi ? HALF_SECOND : HALF_FIRST;
    end

endmodule

// File: rtl/cap_wait_ctr.sv
// Module: cap_wait_ctr
// Holds the per-point wait count and decides, for each buffer event, whether
// the buffer is discarded (count >= code+2) or kept. Start loads the count
// with delay + code + 1 and arms the sequence; the event that takes the count
// from 1 to 0 is the last one. Start outranks a same-cycle event.
module cap_wait_ctr
    import cap_seq_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int BW_W  = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] settle_dly,
    input  logic [BW_W-1:0]  bw_code,
    input  logic             evt_any,
    output logic             busy,
    output buf_act_e         act,
    output logic             last
);

    localparam int MAX_W = (DLY_W > BW_W) ? DLY_W : BW_W;
    localparam int CNT_W = MAX_W + 1;
    localparam int CMP_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [BW_W-1:0]  bw_q;
    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] keep_lim;

    // Purpose: classify the current buffer event
    always_comb begin
        cnt_ext  = CMP_W'(cnt_q);
        keep_lim = CMP_W'(bw_q) + CMP_W'(2);
        act      = ACT_NONE;
        if (busy && evt_any && !start) begin
            act = (cnt_ext >= keep_lim) ? ACT_DISCARD : ACT_KEEP;
        end
        last = (act == ACT_KEEP) && (cnt_q == CNT_W'(1));
    end

    // Purpose: load on start, count down once per accepted buffer event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bw_q  <= '0;
            busy  <= 1'b0;
        end else if (start) begin
            cnt_q <= CNT_W'(settle_dly) + CNT_W'(bw_code) + CNT_W'(1);
            bw_q  <= bw_code;
            busy  <= 1'b1;
        end else if (act != ACT_NONE) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end

    AST_BUSY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0)); // R5
    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R7
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy); // R5

endmodule

// File: rtl/capture_avg_seq.sv
// Module: capture_avg_seq (top)
// Sequences one measurement point over a ping-pong capture buffer: discards
// settle buffers by clearing the accumulators, forwards code+1 buffers for
// accumulation and pulses done on the last. All outputs are registered and
// follow their cause by one cycle. Assumes single-cycle event and start pulses.
module capture_avg_seq
    import cap_seq_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int BW_W  = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] settle_dly,
    input  logic [BW_W-1:0]  bw_code,
    input  logic             evt_lo,
    input  logic             evt_hi,
    output logic             half_sel,
    output logic             acc_clr,
    output logic             proc_en,
    output logic             meas_done
);

    logic     evt_any;
    half_e    evt_half;
    logic     busy;
    buf_act_e act;
    logic     last;

    cap_evt_decode u_dec (
        .evt_lo   (evt_lo),
        .evt_hi   (evt_hi),
        .evt_any  (evt_any),
        .evt_half (evt_half)
    );

    cap_wait_ctr #(
        .DLY_W (DLY_W),
        .BW_W  (BW_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .settle_dly (settle_dly),
        .bw_code    (bw_code),
        .evt_any    (evt_any),
        .busy       (busy),
        .act        (act),
        .last       (last)
    );

    // Purpose: register the control pulses and the half select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_sel  <= 1'b0;
            acc_clr   <= 1'b0;
            proc_en   <= 1'b0;
            meas_done <= 1'b0;
        end else begin
            acc_clr   <= (start && busy) || (act == ACT_DISCARD);
            proc_en   <= (act == ACT_KEEP);
            meas_done <= last;
            if (act != ACT_NONE) begin
                half_sel <= evt_half;
            end
        end
    end

    AST_CLR_PROC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_clr && proc_en)); // R2
    AST_DONE_WITH_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |-> proc_en); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |=> !meas_done); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (!proc_en && !meas_done)); // R6
    AST_SEL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hi && !evt_lo && busy && !start) |=> half_sel); // R4
    AST_SEL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_lo && !evt_hi && busy && !start) |=> !half_sel); // R4
    AST_START_NO_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !proc_en); // R8

endmodule

// File: tb/capture_avg_seq_test.sv
// Directed bench for capture_avg_seq: one task per scenario.
module capture_avg_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] dly = 8'd0;
    logic [7:0] bw = 8'd0;
    logic       evt_lo = 1'b0;
    logic       evt_hi = 1'b0;
    logic       half_sel, acc_clr, proc_en, meas_done;

    int checks = 0;
    int errors = 0;
    int n_clr = 0, n_proc = 0, n_done = 0, n_sel_bad = 0, n_done_bad = 0;
    logic exp_sel = 1'b0;

    capture_avg_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_dly(dly),
        .bw_code(bw), .evt_lo(evt_lo), .evt_hi(evt_hi),
        .half_sel(half_sel), .acc_clr(acc_clr), .proc_en(proc_en),
        .meas_done(meas_done)
    );

    always #5 clk = ~clk;

    // Pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (acc_clr) n_clr++;
            if (proc_en) begin
                n_proc++;
                if (half_sel !== exp_sel) n_sel_bad++;
            end
            if (meas_done) begin
                n_done++;
                if (!proc_en) n_done_bad++;
            end
        end
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_clr = 0; n_proc = 0; n_done = 0; n_sel_bad = 0; n_done_bad = 0;
    endtask

    task automatic do_start(input int d, input int b);
        @(posedge clk); #1;
        dly = 8'(d); bw = 8'(b); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic do_evt(input bit second);
        @(posedge clk); #1;
        evt_hi = second; evt_lo = !second; exp_sel = second;
        @(posedge clk); #1;
        evt_hi = 1'b0; evt_lo = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 outputs in reset", int'({half_sel, acc_clr, proc_en, meas_done}), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 outputs after release", int'({half_sel, acc_clr, proc_en, meas_done}), 0);
    endtask

    task automatic t_idle();
        clear_counts();
        do_evt(1'b1);
        do_evt(1'b0);
        do_evt(1'b1);
        check("R6 idle pulses", n_clr + n_proc + n_done, 0);
        check("R6 idle half_sel unchanged", int'(half_sel), 0);
    endtask

    task automatic t_point(input int d, input int b);
        clear_counts();
        do_start(d, b);
        for (int i = 0; i < d + b + 1; i++) do_evt(i[0]);
        do_evt(1'b0);
        do_evt(1'b1);
        check($sformatf("R2 discards code %0d", b), n_clr, d);
        check($sformatf("R3 forwarded code %0d", b), n_proc, b + 1);
        check($sformatf("R5 done count code %0d", b), n_done + n_done_bad * 100, 1);
        check($sformatf("R4 half_sel mismatches code %0d", b), n_sel_bad, 0);
    endtask

    task automatic t_restart();
        clear_counts();
        do_start(3, 3);
        do_evt(1'b0);
        do_evt(1'b1);
        check("R2 discards before restart", n_clr, 2);
        clear_counts();
        do_start(1, 0);
        @(negedge clk); #1;
        check("R7 clear on restart", n_clr, 1);
        do_evt(1'b0);
        do_evt(1'b1);
        do_evt(1'b0);
        check("R7 clears after restart", n_clr, 2);
        check("R7 forwarded after restart", n_proc, 1);
        check("R7 done after restart", n_done, 1);
    endtask

    task automatic t_start_collide();
        clear_counts();
        @(posedge clk); #1;
        dly = 8'd0; bw = 8'd1; start = 1'b1; evt_lo = 1'b1; exp_sel = 1'b0;
        @(posedge clk); #1;
        start = 1'b0; evt_lo = 1'b0;
        do_evt(1'b1);
        check("R8 collided event ignored (no done yet)", n_done, 0);
        do_evt(1'b0);
        check("R8 forwarded after collision", n_proc, 2);
        check("R8 done after collision", n_done, 1);
    endtask

    task automatic t_latency();
        clear_counts();
        do_start(0, 0);
        @(posedge clk); #1;
        evt_hi = 1'b1; exp_sel = 1'b1;
        @(negedge clk); #1;
        check("R9 no output before edge", int'(proc_en), 0);
        @(posedge clk); #1;
        evt_hi = 1'b0;
        check("R9 proc_en one cycle after event", int'(proc_en), 1);
        check("R5 done with last proc_en", int'(meas_done), 1);
        check("R4 half_sel second half", int'(half_sel), 1);
        @(posedge clk); #1;
        check("R5 done single cycle", int'(meas_done | proc_en), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_point(2, 0);
        t_point(0, 3);
        t_point(5, 39);
        t_point(1, 131);
        t_restart();
        t_start_collide();
        t_latency();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule